// File: doc/BRIEF.md
# Pipelined Eight-Operand Modular Sum

This block reduces eight residues, each already in the range [0, M), to a single residue equal to their total modulo M. The work is split into a three-level binary tree, with one register rank per level. The first level joins neighbouring operands, the second joins those pair results, and the third joins the two halves. Every node adds its two inputs and then forms the difference against M. When that difference is not negative it replaces the raw sum. Because of this, no value anywhere in the tree reaches M, and each register is only as wide as a residue.

Operands enter as a stream beat. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The result leaves as a stream beat that the consumer takes when `out_valid` and `out_ready` are both high. Back-pressure stalls the whole tree at once. While the output beat is offered and refused, nothing moves and `in_ready` is low. Empty slots between beats travel through the tree as bubbles, and beats keep their order.

Top module: `modsum_tree8`

## Requirements
- R1: For every accepted beat, the output beat carries (op0 + op1 + ... + op7) mod MODULUS. Operand k sits in bits [k*RW +: RW] of `in_ops`, where RW = max(1, ceil(log2 MODULUS)).
- R2: With `out_ready` held high, `out_valid` for a beat accepted at clock edge t rises after edge t+2. This is three register ranks. A new beat can be accepted on every edge.
- R3: Every node result and every presented `out_sum` is less than MODULUS when the operands are less than MODULUS.
- R4: Reset is synchronous and active low. After a clock edge with `rst_n` low, `out_valid` is 0 and `out_sum` is 0. A beat in flight before the reset never appears at the output.
- R5: While `out_valid` is high and `out_ready` is low, `out_sum` and `out_valid` hold their values across clock edges.
- R6: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While it is low, an offered input beat is not taken and is not lost.
- R7: Edges where no beat is accepted produce no output beat. Output beats appear in acceptance order, with the same spacing as their inputs when there is no back-pressure.
- R8: Boundary operands give the exact residue. All operands equal to MODULUS-1 give (8*(MODULUS-1)) mod MODULUS. All operands equal to zero give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The tree can take a beat on this edge |
| in_ops | input | 8*RW | Eight packed residues, operand k at [k*RW +: RW] |
| out_valid | output | 1 | A result beat is offered |
| out_ready | input | 1 | The consumer takes the result beat |
| out_sum | output | RW | Sum of the eight operands modulo MODULUS |

## Verification
The assertions check the following on every cycle:
- Every node result stays below the modulus.
- The presented result stays below the modulus.
- Each level turns an advancing beat into a valid slot and an advancing bubble into an empty slot.
- A refused output beat stays frozen.

Only the directed scenarios can show:
- The arithmetic value of the sum.
- The exact three-edge latency from the ports.
- Order and spacing across streams with gaps.
- That a stalled input beat is taken later and not dropped.
- That a mid-stream reset discards the beats in flight.

// File: rtl/modsum_pkg.sv
package modsum_pkg;
  // tree depth is fixed: eight operands, three pairwise levels
  localparam int unsigned LEVELS  = 3;
  localparam int unsigned NUM_OPS = 1 << LEVELS;

  // bits needed to hold a residue below m
  function automatic int unsigned res_width(input int unsigned m);
    return (m <= 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/modsum_node.sv
// Two-input modular adder: raw sum, then conditional subtract of the modulus.
module modsum_node #(
  parameter int unsigned MODULUS = 3,
  parameter int unsigned RW      = 2
) (
  input  logic [RW-1:0] opa,
  input  logic [RW-1:0] opb,
  output logic [RW-1:0] res
);
  localparam int unsigned SW = RW + 1;  // raw sum width, < 2*MODULUS
  localparam int unsigned DW = RW + 2;  // difference width with sign bit

  logic [SW-1:0] raw;
  logic [DW-1:0] diff;

  always_comb begin
    raw  = SW'(opa) + SW'(opb);
    diff = DW'(raw) - DW'(MODULUS);
    if (diff[DW-1]) res = raw[RW-1:0];
    else            res = diff[RW-1:0];
  end

  // R3: with in-range operands the node result never reaches the modulus
  always_comb begin
    if ((32'(opa) < MODULUS) && (32'(opb) < MODULUS))
      assert_node_range_R3: assert (32'(res) < MODULUS);
  end
endmodule

// File: rtl/modsum_level.sv
// One registered tree level: N_IN residues in, N_IN/2 residues out.
module modsum_level #(
  parameter int unsigned MODULUS = 3,
  parameter int unsigned RW      = 2,
  parameter int unsigned N_IN    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       vin,
  input  logic [N_IN-1:0][RW-1:0]    din,
  output logic                       vout,
  output logic [N_IN/2-1:0][RW-1:0]  dout
);
  localparam int unsigned N_OUT = N_IN / 2;

  logic [N_OUT-1:0][RW-1:0] nxt;

  for (genvar n = 0; n < N_OUT; n++) begin : g_node
    modsum_node #(.MODULUS(MODULUS), .RW(RW)) u_node (
      .opa (din[2*n]),
      .opb (din[2*n+1]),
      .res (nxt[n])
    );
  end

  // data registers load only for real beats, so bubbles leave them still
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      dout <= '0;
    end else if (adv) begin
      vout <= vin;
      if (vin) dout <= nxt;
    end
  end

  // R2: an advancing beat occupies this level on the next cycle
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && vin) |=> vout);

  // R7: an advancing bubble leaves this level empty
  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !vin) |=> !vout);
endmodule

// File: rtl/modsum_tree8.sv
module modsum_tree8 #(
  parameter int unsigned MODULUS = 3,
  localparam int unsigned RW     = modsum_pkg::res_width(MODULUS),
  localparam int unsigned NOPS   = modsum_pkg::NUM_OPS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NOPS-1:0][RW-1:0]   in_ops,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [RW-1:0]             out_sum
);
  localparam int unsigned LEVELS = modsum_pkg::LEVELS;

  logic adv;

  // global stall: the tree moves unless the final beat is refused
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int unsigned NIN = NOPS >> lv;
    logic [NIN-1:0][RW-1:0]   d;
    logic                     vi;
    logic [NIN/2-1:0][RW-1:0] q;
    logic                     v;

    if (lv == 0) begin : g_src_port
      assign d  = in_ops;
      assign vi = in_valid;
    end else begin : g_src_prev
      assign d  = g_lvl[lv-1].q;
      assign vi = g_lvl[lv-1].v;
    end

    modsum_level #(.MODULUS(MODULUS), .RW(RW), .N_IN(NIN)) u_level (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .vin   (vi),
      .din   (d),
      .vout  (v),
      .dout  (q)
    );
  end

  assign out_valid = g_lvl[LEVELS-1].v;
  assign out_sum   = g_lvl[LEVELS-1].q[0];

  // R5: a refused result beat is frozen
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R3: a presented result is always a proper residue
  assert_out_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_sum) < MODULUS));
endmodule

// File: tb/modsum_tree8_tb.sv
module modsum_tree8_tb;
  localparam int unsigned M  = 3;
  localparam int unsigned RW = modsum_pkg::res_width(M);

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic                 in_ready;
  logic [7:0][RW-1:0]   in_ops;
  logic                 out_valid;
  logic                 out_ready;
  logic [RW-1:0]        out_sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  modsum_tree8 #(.MODULUS(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ops(in_ops), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_sum(input logic [7:0][RW-1:0] ops);
    int s = 0;
    for (int k = 0; k < 8; k++) s += int'(ops[k]);
    return s % M;
  endfunction

  function automatic logic [7:0][RW-1:0] rand_ops();
    logic [7:0][RW-1:0] o;
    for (int k = 0; k < 8; k++) o[k] = RW'($urandom_range(M-1, 0));
    return o;
  endfunction

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R4: reset clears the output and discards beats in flight
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_ops = '0;
    idle_cycles(2);
    check("R4 out_valid in reset", int'(out_valid), 0);
    check("R4 out_sum in reset", int'(out_sum), 0);
    rst_n = 1'b1;
    // two beats in flight, then a reset edge
    in_valid = 1'b1; in_ops = '1 & {8{RW'(M-1)}};
    idle_cycles(2);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R4 out_valid after mid reset", int'(out_valid), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4 no stale beat", int'(out_valid), 0);
    end
  endtask

  // R2, R1: single beat latency
  task automatic t_latency();
    logic [7:0][RW-1:0] o = rand_ops();
    in_ops = o; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 not valid after edge 1", int'(out_valid), 0);
    @(negedge clk);
    check("R2 not valid after edge 2", int'(out_valid), 0);
    @(negedge clk);
    check("R2 valid after edge 3", int'(out_valid), 1);
    check("R1 single beat sum", int'(out_sum), ref_sum(o));
    @(negedge clk);
    check("R7 single beat one slot", int'(out_valid), 0);
  endtask

  // R8: boundary operands
  task automatic t_extremes();
    logic [7:0][RW-1:0] o;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 8; k++) o[k] = (c == 0) ? RW'(M-1) : '0;
      in_ops = o; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      idle_cycles(2);
      check("R8 valid", int'(out_valid), 1);
      check("R8 boundary sum", int'(out_sum), (c == 0) ? (8*(M-1)) % M : 0);
    end
  endtask

  // R1, R2: back-to-back stream at full rate
  task automatic t_stream();
    int exp [24];
    out_ready = 1'b1;
    for (int i = 0; i < 24 + 3; i++) begin
      if (i >= 3) begin
        check("R2 stream valid", int'(out_valid), 1);
        check("R1 stream sum", int'(out_sum), exp[i-3]);
      end
      if (i < 24) begin
        in_ops = rand_ops(); exp[i] = ref_sum(in_ops); in_valid = 1'b1;
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    check("R7 stream drained", int'(out_valid), 0);
  endtask

  // R7: gaps keep their spacing
  task automatic t_bubbles();
    bit pat [8] = '{1, 0, 0, 1, 1, 0, 1, 0};
    int exp [8];
    out_ready = 1'b1;
    for (int i = 0; i < 11; i++) begin
      if (i >= 3) begin
        check("R7 slot valid", int'(out_valid), int'(pat[i-3]));
        if (pat[i-3]) check("R1 gapped sum", int'(out_sum), exp[i-3]);
      end
      if (i < 8) begin
        in_ops = rand_ops(); exp[i] = ref_sum(in_ops); in_valid = pat[i];
      end else in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  // R5, R6: stall with a refused output
  task automatic t_backpressure();
    int exp [4];
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      in_ops = rand_ops(); exp[i] = ref_sum(in_ops); in_valid = 1'b1;
      if (i < 3) @(negedge clk);
    end
    // beats 0..2 taken, beat 3 is offered now
    for (int i = 0; i < 4; i++) begin
      check("R5 held valid", int'(out_valid), 1);
      check("R5 held sum", int'(out_sum), exp[0]);
      check("R6 in_ready low in stall", int'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #0.1;
    check("R6 in_ready back", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < 4; i++) begin
      check("R6 no beat lost valid", int'(out_valid), 1);
      check("R6 order after stall", int'(out_sum), exp[i]);
      @(negedge clk);
    end
    check("R7 drained after stall", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_ops = '0;
    t_reset();
    t_latency();
    t_extremes();
    t_stream();
    t_bubbles();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule